// File: doc/BRIEF.md
# Dual-Clock Width-Converting Burst Buffer

This block sits between a 32-bit bus-side engine and an 8-bit pixel engine. Each engine runs on its own clock, and the two clocks have no fixed ratio. The block holds two regions. The inbound region is written by the bus side one 32-bit word at a time and read by the pixel side one byte-wide pixel at a time. The outbound region works the other way: the pixel side writes single pixels and the bus side reads whole words. Each region is split into two halves of one burst each, so a writer can fill one half while the reader drains the other.

Burst position on every side is tracked by a plain counter; there is no FIFO. When a writer finishes a burst, it flips a toggle. The toggle is synchronized into the reader's clock and turned into a single-cycle pulse, which makes the burst visible to the reader. When the reader finishes that burst, it returns a toggle the same way, and the writer may then reuse that half. These two strobes are the only flow control between the domains.

BURST is the number of 32-bit words in one burst. It must be a power of two and at least 2.

Top module: `dual_clk_burst_buf`

## Requirements
- R1: While reset is active and after it is released, `bus_wr_rdy_o` and `pix_wr_rdy_o` are 1, and `bus_rd_vld_o` and `pix_rd_vld_o` are 0.
- R2: Inbound pixels leave in little-endian order. Pixel k of a burst is byte k mod 4 of word k/4 of that burst, so bits 7:0 of a word come out first and bits 31:24 come out last.
- R3: A read accepted on a rising clock edge (`*_rd_en_i` high while `*_rd_vld_o` is high) drives its data on the read-data output from that same edge, and the output holds that value until the next accepted read.
- R4: Outbound pixels are packed little-endian. The four consecutive pixel writes 4n..4n+3 of a burst form word n, with write 4n in bits 7:0 and write 4n+3 in bits 31:24.
- R5: `pix_rd_vld_o` stays 0 until all BURST words of an inbound burst have been written. A partial burst is never visible to the pixel side.
- R6: Each writer may get at most two bursts ahead of its reader. Its ready output falls once two unacknowledged bursts are held. It rises again only after the reader has consumed a whole burst and the acknowledge has crossed back.
- R7: A write enable while the matching ready is 0, or a read enable while the matching valid is 0, has no effect. No data is stored, and no counter moves.
- R8: Bursts are delivered in the order they were written, with the halves alternating, including when a half is reused after its acknowledge.
- R9: `bus_rd_vld_o` stays 0 until all 4*BURST pixels of an outbound burst have been written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_b_i | input | 1 | Bus-side clock |
| clk_p_i | input | 1 | Pixel-side clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| bus_wr_en_i | input | 1 | Bus writes one inbound word |
| bus_wr_data_i | input | 32 | Inbound word |
| bus_wr_rdy_o | output | 1 | An inbound half is free |
| bus_rd_en_i | input | 1 | Bus reads one outbound word |
| bus_rd_data_o | output | 32 | Outbound word, registered |
| bus_rd_vld_o | output | 1 | An outbound burst is complete |
| pix_rd_en_i | input | 1 | Pixel side reads one inbound pixel |
| pix_rd_data_o | output | 8 | Inbound pixel, registered |
| pix_rd_vld_o | output | 1 | An inbound burst is complete |
| pix_wr_en_i | input | 1 | Pixel side writes one outbound pixel |
| pix_wr_data_i | input | 8 | Outbound pixel |
| pix_wr_rdy_o | output | 1 | An outbound half is free |

## Verification
The hardest state to reach is a full writer, with both halves written and none acknowledged, while enables are still arriving.

The bench produces it by writing two complete bursts before the reader takes anything. It then drives a write of a marker word into the full buffer and confirms that ready stays low for many cycles. It drains one burst, waits for the acknowledge to raise ready, and reuses the freed half. Finally it reads every remaining pixel to show that the marker word never entered the buffer and that the burst order held.

A partial burst held back across many reader cycles checks that visibility comes only from the completion strobe.

// File: rtl/bbuf_pkg.sv
package bbuf_pkg;
  localparam int BUS_W   = 32;
  localparam int PIX_W   = 8;
  localparam int LANES   = BUS_W / PIX_W;
  localparam int LANE_AW = $clog2(LANES);
  typedef logic [LANES-1:0][PIX_W-1:0] word_t;
endpackage

// File: rtl/bbuf_tog_sync.sv
// Toggle crossing: two sync flops, then an edge detect that gives a one-cycle pulse.
module bbuf_tog_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tog_i,
  output logic pulse_o
);
  logic [2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[1:0], tog_i};
  end

  assign pulse_o = sh_q[2] ^ sh_q[1];
endmodule

// File: rtl/bbuf_producer.sv
// Writer side of one direction: burst counter, half select, occupancy of the two halves.
module bbuf_producer #(
  parameter int UNITS = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic                     ack_i,
  output logic                     rdy_o,
  output logic                     we_o,
  output logic [$clog2(UNITS):0]   addr_o,
  output logic                     tog_o,
  output logic [1:0]               occ_o
);
  localparam int CW = $clog2(UNITS);

  logic [CW-1:0] cnt_q;
  logic          half_q;
  logic          last;

  assign rdy_o  = (occ_o != 2'd2);
  assign we_o   = en_i & rdy_o;
  assign last   = we_o && (cnt_q == CW'(UNITS-1));
  assign addr_o = {half_q, cnt_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
      tog_o  <= 1'b0;
      occ_o  <= 2'd0;
    end else begin
      if (we_o) cnt_q <= last ? '0 : cnt_q + CW'(1);
      if (last) begin
        half_q <= ~half_q;
        tog_o  <= ~tog_o;
      end
      case ({last, ack_i})
        2'b10:   occ_o <= occ_o + 2'd1;
        2'b01:   occ_o <= occ_o - 2'd1;
        default: occ_o <= occ_o;
      endcase
    end
  end
endmodule

// File: rtl/bbuf_consumer.sv
// Reader side of one direction: counts bursts made visible and returns an acknowledge toggle.
module bbuf_consumer #(
  parameter int UNITS = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic                     done_i,
  output logic                     vld_o,
  output logic                     re_o,
  output logic [$clog2(UNITS):0]   addr_o,
  output logic                     tog_o,
  output logic [1:0]               avail_o
);
  localparam int CW = $clog2(UNITS);

  logic [CW-1:0] cnt_q;
  logic          half_q;
  logic          last;

  assign vld_o  = (avail_o != 2'd0);
  assign re_o   = en_i & vld_o;
  assign last   = re_o && (cnt_q == CW'(UNITS-1));
  assign addr_o = {half_q, cnt_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      half_q  <= 1'b0;
      tog_o   <= 1'b0;
      avail_o <= 2'd0;
    end else begin
      if (re_o) cnt_q <= last ? '0 : cnt_q + CW'(1);
      if (last) begin
        half_q <= ~half_q;
        tog_o  <= ~tog_o;
      end
      case ({done_i, last})
        2'b10:   avail_o <= avail_o + 2'd1;
        2'b01:   avail_o <= avail_o - 2'd1;
        default: avail_o <= avail_o;
      endcase
    end
  end
endmodule

// File: rtl/bbuf_asym_mem.sv
// Shared storage: a word port on the bus clock and a byte port on the pixel clock.
// The inbound region is word-written and byte-read; the outbound region is byte-written per lane and word-read.
module bbuf_asym_mem
  import bbuf_pkg::*;
#(
  parameter int WORDS = 32
) (
  input  logic                              clk_b_i,
  input  logic                              rst_ni,
  input  logic                              b_we_i,
  input  logic [$clog2(WORDS)-1:0]          b_waddr_i,
  input  logic [BUS_W-1:0]                  b_wdata_i,
  input  logic                              b_re_i,
  input  logic [$clog2(WORDS)-1:0]          b_raddr_i,
  output logic [BUS_W-1:0]                  b_rdata_o,
  input  logic                              clk_p_i,
  input  logic                              p_we_i,
  input  logic [$clog2(WORDS)+LANE_AW-1:0]  p_waddr_i,
  input  logic [PIX_W-1:0]                  p_wdata_i,
  input  logic                              p_re_i,
  input  logic [$clog2(WORDS)+LANE_AW-1:0]  p_raddr_i,
  output logic [PIX_W-1:0]                  p_rdata_o
);
  localparam int WAW = $clog2(WORDS);

  word_t in_mem [WORDS];
  word_t out_word;

  always_ff @(posedge clk_b_i) begin
    if (b_we_i) in_mem[b_waddr_i] <= b_wdata_i;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_out_lane
    logic [PIX_W-1:0] lane_mem [WORDS];
    always_ff @(posedge clk_p_i) begin
      if (p_we_i && (p_waddr_i[LANE_AW-1:0] == LANE_AW'(l)))
        lane_mem[p_waddr_i[WAW+LANE_AW-1:LANE_AW]] <= p_wdata_i;
    end
    assign out_word[l] = lane_mem[b_raddr_i];
  end

  always_ff @(posedge clk_b_i or negedge rst_ni) begin
    if (!rst_ni)     b_rdata_o <= '0;
    else if (b_re_i) b_rdata_o <= out_word;
  end

  always_ff @(posedge clk_p_i or negedge rst_ni) begin
    if (!rst_ni)     p_rdata_o <= '0;
    else if (p_re_i) p_rdata_o <= in_mem[p_raddr_i[WAW+LANE_AW-1:LANE_AW]][p_raddr_i[LANE_AW-1:0]];
  end
endmodule

// File: rtl/dual_clk_burst_buf.sv
module dual_clk_burst_buf
  import bbuf_pkg::*;
#(
  parameter int BURST = 16
) (
  input  logic             clk_b_i,
  input  logic             clk_p_i,
  input  logic             rst_ni,
  input  logic             bus_wr_en_i,
  input  logic [BUS_W-1:0] bus_wr_data_i,
  output logic             bus_wr_rdy_o,
  input  logic             bus_rd_en_i,
  output logic [BUS_W-1:0] bus_rd_data_o,
  output logic             bus_rd_vld_o,
  input  logic             pix_rd_en_i,
  output logic [PIX_W-1:0] pix_rd_data_o,
  output logic             pix_rd_vld_o,
  input  logic             pix_wr_en_i,
  input  logic [PIX_W-1:0] pix_wr_data_i,
  output logic             pix_wr_rdy_o
);
  localparam int WORDS = 2 * BURST;
  localparam int WAW   = $clog2(WORDS);
  localparam int PAW   = WAW + LANE_AW;
  localparam int PIXB  = BURST * LANES;

  logic           in_we, in_re, out_we, out_re;
  logic [WAW-1:0] in_waddr, out_raddr;
  logic [PAW-1:0] in_raddr, out_waddr;
  logic           in_done_tog, in_ack_tog, out_done_tog, out_ack_tog;
  logic           in_done_p, in_ack_b, out_done_b, out_ack_p;
  logic [1:0]     in_occ, in_avail, out_occ, out_avail;

  // inbound: bus writes words, pixel engine reads bytes
  bbuf_producer #(.UNITS(BURST)) i_in_prod (
    .clk_i(clk_b_i), .rst_ni(rst_ni), .en_i(bus_wr_en_i), .ack_i(in_ack_b),
    .rdy_o(bus_wr_rdy_o), .we_o(in_we), .addr_o(in_waddr), .tog_o(in_done_tog), .occ_o(in_occ)
  );
  bbuf_tog_sync i_in_done_sync (.clk_i(clk_p_i), .rst_ni(rst_ni), .tog_i(in_done_tog), .pulse_o(in_done_p));
  bbuf_consumer #(.UNITS(PIXB)) i_in_cons (
    .clk_i(clk_p_i), .rst_ni(rst_ni), .en_i(pix_rd_en_i), .done_i(in_done_p),
    .vld_o(pix_rd_vld_o), .re_o(in_re), .addr_o(in_raddr), .tog_o(in_ack_tog), .avail_o(in_avail)
  );
  bbuf_tog_sync i_in_ack_sync (.clk_i(clk_b_i), .rst_ni(rst_ni), .tog_i(in_ack_tog), .pulse_o(in_ack_b));

  // outbound: pixel engine writes bytes, bus reads words
  bbuf_producer #(.UNITS(PIXB)) i_out_prod (
    .clk_i(clk_p_i), .rst_ni(rst_ni), .en_i(pix_wr_en_i), .ack_i(out_ack_p),
    .rdy_o(pix_wr_rdy_o), .we_o(out_we), .addr_o(out_waddr), .tog_o(out_done_tog), .occ_o(out_occ)
  );
  bbuf_tog_sync i_out_done_sync (.clk_i(clk_b_i), .rst_ni(rst_ni), .tog_i(out_done_tog), .pulse_o(out_done_b));
  bbuf_consumer #(.UNITS(BURST)) i_out_cons (
    .clk_i(clk_b_i), .rst_ni(rst_ni), .en_i(bus_rd_en_i), .done_i(out_done_b),
    .vld_o(bus_rd_vld_o), .re_o(out_re), .addr_o(out_raddr), .tog_o(out_ack_tog), .avail_o(out_avail)
  );
  bbuf_tog_sync i_out_ack_sync (.clk_i(clk_p_i), .rst_ni(rst_ni), .tog_i(out_ack_tog), .pulse_o(out_ack_p));

  bbuf_asym_mem #(.WORDS(WORDS)) i_mem (
    .clk_b_i(clk_b_i), .rst_ni(rst_ni),
    .b_we_i(in_we), .b_waddr_i(in_waddr), .b_wdata_i(bus_wr_data_i),
    .b_re_i(out_re), .b_raddr_i(out_raddr), .b_rdata_o(bus_rd_data_o),
    .clk_p_i(clk_p_i),
    .p_we_i(out_we), .p_waddr_i(out_waddr), .p_wdata_i(pix_wr_data_i),
    .p_re_i(in_re), .p_raddr_i(in_raddr), .p_rdata_o(pix_rd_data_o)
  );
endmodule

// File: rtl/bbuf_chk.sv
module bbuf_chk (
  input logic       clk_b_i,
  input logic       clk_p_i,
  input logic       rst_ni,
  input logic       bus_wr_en_i,
  input logic       bus_wr_rdy_o,
  input logic       bus_rd_en_i,
  input logic       bus_rd_vld_o,
  input logic       pix_rd_en_i,
  input logic       pix_rd_vld_o,
  input logic       pix_wr_en_i,
  input logic       pix_wr_rdy_o,
  input logic [1:0] in_occ,
  input logic [1:0] out_occ,
  input logic [1:0] in_avail,
  input logic [1:0] out_avail,
  input logic       in_done_p,
  input logic       in_ack_b,
  input logic       out_done_b,
  input logic       out_ack_p
);
  // R6
  in_occ_max_chk: assert property (@(posedge clk_b_i) disable iff (!rst_ni) in_occ <= 2'd2);
  // R6
  out_occ_max_chk: assert property (@(posedge clk_p_i) disable iff (!rst_ni) out_occ <= 2'd2);
  // R6
  in_avail_max_chk: assert property (@(posedge clk_p_i) disable iff (!rst_ni) in_avail <= 2'd2);
  // R6
  out_avail_max_chk: assert property (@(posedge clk_b_i) disable iff (!rst_ni) out_avail <= 2'd2);
  // R6
  bus_rdy_fall_chk: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    $fell(bus_wr_rdy_o) |-> $past(bus_wr_en_i));
  // R6
  bus_rdy_rise_chk: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    $rose(bus_wr_rdy_o) |-> $past(in_ack_b));
  // R6
  pix_rdy_fall_chk: assert property (@(posedge clk_p_i) disable iff (!rst_ni)
    $fell(pix_wr_rdy_o) |-> $past(pix_wr_en_i));
  // R6
  pix_rdy_rise_chk: assert property (@(posedge clk_p_i) disable iff (!rst_ni)
    $rose(pix_wr_rdy_o) |-> $past(out_ack_p));
  // R5
  pix_vld_rise_chk: assert property (@(posedge clk_p_i) disable iff (!rst_ni)
    $rose(pix_rd_vld_o) |-> $past(in_done_p));
  // R7
  pix_vld_fall_chk: assert property (@(posedge clk_p_i) disable iff (!rst_ni)
    $fell(pix_rd_vld_o) |-> $past(pix_rd_en_i));
  // R9
  bus_vld_rise_chk: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    $rose(bus_rd_vld_o) |-> $past(out_done_b));
  // R7
  bus_vld_fall_chk: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    $fell(bus_rd_vld_o) |-> $past(bus_rd_en_i));
endmodule

bind dual_clk_burst_buf bbuf_chk i_chk (.*);

// File: tb/test_dual_clk_burst_buf.sv
module test_dual_clk_burst_buf;
  localparam int CLK_B_PERIOD = 10;
  localparam int CLK_P_PERIOD = 7;
  localparam int BURST = 16;
  localparam int PIXB  = BURST * 4;

  logic        clk_b = 0, clk_p = 0, rst_ni = 0;
  logic        bus_wr_en_i = 0, bus_rd_en_i = 0, pix_rd_en_i = 0, pix_wr_en_i = 0;
  logic [31:0] bus_wr_data_i = '0;
  logic [7:0]  pix_wr_data_i = '0;
  logic [31:0] bus_rd_data_o;
  logic [7:0]  pix_rd_data_o;
  logic        bus_wr_rdy_o, bus_rd_vld_o, pix_rd_vld_o, pix_wr_rdy_o;
  int          checks = 0, fails = 0;
  bit          done = 0;

  always #(CLK_B_PERIOD/2) clk_b = ~clk_b;
  always #(CLK_P_PERIOD/2.0) clk_p = ~clk_p;

  dual_clk_burst_buf #(.BURST(BURST)) i_dual_clk_burst_buf (
    .clk_b_i(clk_b), .clk_p_i(clk_p), .rst_ni(rst_ni),
    .bus_wr_en_i(bus_wr_en_i), .bus_wr_data_i(bus_wr_data_i), .bus_wr_rdy_o(bus_wr_rdy_o),
    .bus_rd_en_i(bus_rd_en_i), .bus_rd_data_o(bus_rd_data_o), .bus_rd_vld_o(bus_rd_vld_o),
    .pix_rd_en_i(pix_rd_en_i), .pix_rd_data_o(pix_rd_data_o), .pix_rd_vld_o(pix_rd_vld_o),
    .pix_wr_en_i(pix_wr_en_i), .pix_wr_data_i(pix_wr_data_i), .pix_wr_rdy_o(pix_wr_rdy_o)
  );

  function automatic logic [7:0] pbyte(int b, int k);
    logic [31:0] t;
    t = 32'(b * 37 + k * 3 + 1);
    return t[7:0];
  endfunction

  function automatic logic [31:0] pword(int b, int i);
    return {pbyte(b, 4*i+3), pbyte(b, 4*i+2), pbyte(b, 4*i+1), pbyte(b, 4*i)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [31:0] w);
    @(negedge clk_b);
    while (!bus_wr_rdy_o) @(negedge clk_b);
    bus_wr_en_i = 1; bus_wr_data_i = w;
    @(negedge clk_b);
    bus_wr_en_i = 0;
  endtask

  task automatic bus_read(output logic [31:0] w);
    @(negedge clk_b);
    while (!bus_rd_vld_o) @(negedge clk_b);
    bus_rd_en_i = 1;
    @(negedge clk_b);
    bus_rd_en_i = 0;
    w = bus_rd_data_o;
  endtask

  task automatic pix_write(input logic [7:0] d);
    @(negedge clk_p);
    while (!pix_wr_rdy_o) @(negedge clk_p);
    pix_wr_en_i = 1; pix_wr_data_i = d;
    @(negedge clk_p);
    pix_wr_en_i = 0;
  endtask

  task automatic pix_read(output logic [7:0] d);
    @(negedge clk_p);
    while (!pix_rd_vld_o) @(negedge clk_p);
    pix_rd_en_i = 1;
    @(negedge clk_p);
    pix_rd_en_i = 0;
    d = pix_rd_data_o;
  endtask

  task automatic write_in_burst(input int b, input int first, input int last);
    for (int i = first; i <= last; i++) bus_write(pword(b, i));
  endtask

  task automatic read_in_burst(input int b);
    int bad = 0;
    logic [7:0] d;
    for (int k = 0; k < PIXB; k++) begin
      pix_read(d);
      if (d !== pbyte(b, k) && bad < 3) begin
        bad++;
        chk(0, "R2 R3 R8 inbound pixel", {24'h0, d}, {24'h0, pbyte(b, k)});
      end
    end
    if (bad == 0) chk(1, "R2 R3 R8", 0, 0);
  endtask

  task automatic write_out_burst(input int b, input int first, input int last);
    for (int k = first; k <= last; k++) pix_write(pbyte(b, k));
  endtask

  task automatic read_out_burst(input int b);
    int bad = 0;
    logic [31:0] w;
    for (int i = 0; i < BURST; i++) begin
      bus_read(w);
      if (w !== pword(b, i) && bad < 3) begin
        bad++;
        chk(0, "R4 R3 R8 outbound word", w, pword(b, i));
      end
    end
    if (bad == 0) chk(1, "R4 R3 R8", 0, 0);
  endtask

  task automatic t_reset;
    chk(bus_wr_rdy_o === 1'b1 && pix_wr_rdy_o === 1'b1, "R1 ready in reset", {bus_wr_rdy_o, pix_wr_rdy_o}, 2'b11);
    chk(bus_rd_vld_o === 1'b0 && pix_rd_vld_o === 1'b0, "R1 valid in reset", {bus_rd_vld_o, pix_rd_vld_o}, 0);
    rst_ni = 1;
    @(negedge clk_b);
    chk(bus_wr_rdy_o === 1'b1 && pix_wr_rdy_o === 1'b1, "R1 ready after reset", {bus_wr_rdy_o, pix_wr_rdy_o}, 2'b11);
    chk(bus_rd_vld_o === 1'b0 && pix_rd_vld_o === 1'b0, "R1 valid after reset", {bus_rd_vld_o, pix_rd_vld_o}, 0);
  endtask

  task automatic t_inbound_single;
    int n;
    // R7: reads while nothing is valid must not advance the read position
    @(negedge clk_p);
    pix_rd_en_i = 1;
    repeat (3) @(negedge clk_p);
    pix_rd_en_i = 0;
    write_in_burst(0, 0, BURST-2);
    repeat (30) @(negedge clk_p);
    chk(pix_rd_vld_o === 1'b0, "R5 partial burst hidden", pix_rd_vld_o, 0);
    write_in_burst(0, BURST-1, BURST-1);
    n = 0;
    while (!pix_rd_vld_o && n < 50) begin @(negedge clk_p); n++; end
    chk(pix_rd_vld_o === 1'b1, "R5 full burst visible", pix_rd_vld_o, 1);
    read_in_burst(0);
  endtask

  task automatic t_inbound_double;
    int n;
    write_in_burst(1, 0, BURST-1);
    write_in_burst(2, 0, BURST-1);
    @(negedge clk_b);
    chk(bus_wr_rdy_o === 1'b0, "R6 full after two bursts", bus_wr_rdy_o, 0);
    // R7: writes into a full buffer are dropped
    bus_wr_en_i = 1; bus_wr_data_i = 32'hDEADBEEF;
    repeat (3) @(negedge clk_b);
    bus_wr_en_i = 0;
    repeat (40) @(negedge clk_p);
    chk(bus_wr_rdy_o === 1'b0, "R6 R7 stays full without ack", bus_wr_rdy_o, 0);
    read_in_burst(1);
    n = 0;
    while (!bus_wr_rdy_o && n < 50) begin @(negedge clk_b); n++; end
    chk(bus_wr_rdy_o === 1'b1, "R6 ready after ack", bus_wr_rdy_o, 1);
    write_in_burst(3, 0, BURST-1);
    read_in_burst(2);
    read_in_burst(3);
    @(negedge clk_p);
    chk(pix_rd_vld_o === 1'b0, "R8 drained", pix_rd_vld_o, 0);
  endtask

  task automatic t_outbound;
    int n;
    // R7: bus reads while nothing is valid must be ignored
    @(negedge clk_b);
    bus_rd_en_i = 1;
    repeat (3) @(negedge clk_b);
    bus_rd_en_i = 0;
    write_out_burst(5, 0, PIXB-2);
    repeat (30) @(negedge clk_b);
    chk(bus_rd_vld_o === 1'b0, "R9 partial burst hidden", bus_rd_vld_o, 0);
    write_out_burst(5, PIXB-1, PIXB-1);
    n = 0;
    while (!bus_rd_vld_o && n < 50) begin @(negedge clk_b); n++; end
    chk(bus_rd_vld_o === 1'b1, "R9 full burst visible", bus_rd_vld_o, 1);
    read_out_burst(5);
    write_out_burst(6, 0, PIXB-1);
    write_out_burst(7, 0, PIXB-1);
    @(negedge clk_p);
    chk(pix_wr_rdy_o === 1'b0, "R6 outbound full", pix_wr_rdy_o, 0);
    pix_wr_en_i = 1; pix_wr_data_i = 8'hEE;
    repeat (3) @(negedge clk_p);
    pix_wr_en_i = 0;
    read_out_burst(6);
    n = 0;
    while (!pix_wr_rdy_o && n < 50) begin @(negedge clk_p); n++; end
    chk(pix_wr_rdy_o === 1'b1, "R6 outbound ready after ack", pix_wr_rdy_o, 1);
    read_out_burst(7);
  endtask

  initial begin
    repeat (3) @(negedge clk_b);
    t_reset();
    t_inbound_single();
    t_inbound_double();
    t_outbound();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_B_PERIOD * 100000);
    if (!done) begin
      checks++; fails++;
      $display("watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule